// File: doc/BRIEF.md
# SPI-Mode Memory Card Command Sequencer

This block issues a single command to a memory card running in SPI mode and gathers the card's reply. A host presents a 6-bit opcode, a 32-bit argument and a reply-type code, then pulses `start`. The sequencer drives the card's chip select, serial clock and data-out line. It samples the card's data-in line and returns the status byte plus any extra reply bytes. When it finishes it raises `done` for one cycle, with flags that mark a timeout or a bad status.

A second mode wakes a freshly powered card. With `wake` high at `start`, the block clocks a fixed run of all-ones bytes while chip select stays inactive. The serial clock comes from one of two divisors. The slow one serves the go-idle command and the wake run, and the fast one serves everything else. Data-block transfers after the command phase belong to a neighbouring block.

Top module: `spi_card_cmd_seq`

## Requirements
- R1: With `wake` high at `start`, the block clocks exactly WAKE_BYTES bytes of 0xFF while `cs_n` stays high, then pulses `done`.
- R2: A command sends eight bytes MSB first with `cs_n` low, in this order: 0xFF, 0x40 | opcode, argument[31:24], [23:16], [15:8], [7:0], CRC byte, 0xFF.
- R3: The CRC byte is 0x95 for opcode 0, 0x87 for opcode 8 and 0x00 for any other opcode.
- R4: Each half period of `sclk` lasts SLOW_DIV+1 clock cycles for opcode 0 and wake runs, and FAST_DIV+1 cycles for all other opcodes.
- R5: After the frame, the block clocks 0xFF bytes and reads the card's output until a byte arrives with bit 7 clear. That byte appears on `r1`.
- R6: If POLL_LIMIT reply bytes all have bit 7 set, the block ends with `timeout` high and `error` low.
- R7: `rsp_type` 1 reads one more byte into `r2_hi`. `rsp_type` 2 reads four more bytes into `r_word`, with the first byte most significant. `rsp_type` 0 or 3 reads no extra byte.
- R8: `error` is high after `done` when the status byte is neither 0x00 nor 0x01.
- R9: `cs_n` stays low from the first frame byte until the last reply byte. It then goes high for exactly one trailing 0xFF byte before `done`.
- R10: SPI mode 0: `sclk` idles low, `mosi` changes only while `sclk` is low, and `miso` is sampled on the rising edge.
- R11: `busy` is high from the cycle after `start` until `done`. `done` is a one-cycle pulse, and a `start` seen while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| wake | input | 1 | Selects the wake run instead of a command |
| opcode | input | 6 | Command index |
| arg | input | 32 | Command argument |
| rsp_type | input | 2 | 0/3 status only, 1 two-byte, 2 status plus 32-bit word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | No status byte within POLL_LIMIT bytes |
| error | output | 1 | Status byte other than 0x00/0x01 |
| r1 | output | 8 | Status byte |
| r2_hi | output | 8 | Second status byte for type 1 |
| r_word | output | 32 | Extra word for type 2 |
| cs_n | output | 1 | Card chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Data to card |
| miso | input | 1 | Data from card |

## Verification
The hardest situation to reach is the poll boundary. A timeout needs the card to answer all-ones for the full poll window. A status byte must also be recognised only when it follows a run of busy bytes. The bench models the card on the serial pins. That model stays silent for the first eight bytes of each chip-select-low window, then plays a queued reply. An empty queue produces the timeout, and leading 0xFF entries move the status byte by a chosen amount. A second start pulse issued in the middle of a transfer shows that it does not disturb the frame that the scoreboard expects.

// File: rtl/spi_card_cmd_seq.sv
module spi_card_cmd_seq #(
  parameter int SLOW_DIV   = 144,
  parameter int FAST_DIV   = 48,
  parameter int WAKE_BYTES = 20,
  parameter int POLL_LIMIT = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        wake,
  input  logic [5:0]  opcode,
  input  logic [31:0] arg,
  input  logic [1:0]  rsp_type,
  output logic        busy,
  output logic        done,
  output logic        timeout,
  output logic        error,
  output logic [7:0]  r1,
  output logic [7:0]  r2_hi,
  output logic [31:0] r_word,
  output logic        cs_n,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  localparam int MAXD = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int DW   = $clog2(MAXD + 2);
  localparam int IW   = $clog2(WAKE_BYTES + 9);
  localparam int PW   = $clog2(POLL_LIMIT + 1);

  typedef enum logic [2:0] {S_IDLE, S_WAKE, S_FRAME, S_POLL, S_EXTRA, S_TAIL} st_t;
  st_t state;

  logic [7:0]    tx_sr, rx_sr, frame_byte;
  logic [2:0]    bit_cnt;
  logic [DW-1:0] div_cnt;
  logic          active, slow_q;
  logic [IW-1:0] idx;
  logic [PW-1:0] poll_cnt;
  logic [5:0]    op_q;
  logic [31:0]   arg_q;
  logic [1:0]    typ_q;

  wire [DW-1:0] div_lim  = slow_q ? DW'(SLOW_DIV) : DW'(FAST_DIV);
  wire          tick     = active && (div_cnt == div_lim);
  wire          byte_end = tick && sclk && (bit_cnt == 3'd7);
  wire [7:0]    crc      = (op_q == 6'd0) ? 8'h95 : (op_q == 6'd8) ? 8'h87 : 8'h00;

  assign busy = (state != S_IDLE);
  assign mosi = tx_sr[7];

  always_comb begin
    case (idx[2:0])
      3'd1:    frame_byte = {2'b01, op_q};
      3'd2:    frame_byte = arg_q[31:24];
      3'd3:    frame_byte = arg_q[23:16];
      3'd4:    frame_byte = arg_q[15:8];
      3'd5:    frame_byte = arg_q[7:0];
      3'd6:    frame_byte = crc;
      default: frame_byte = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;  tx_sr <= 8'hFF;  rx_sr <= 8'hFF;  bit_cnt <= '0;
      div_cnt <= '0;    active <= 1'b0;  slow_q <= 1'b1;  idx <= '0;
      poll_cnt <= '0;   op_q <= '0;      arg_q <= '0;     typ_q <= '0;
      done <= 1'b0;     timeout <= 1'b0; error <= 1'b0;   r1 <= 8'hFF;
      r2_hi <= '0;      r_word <= '0;    cs_n <= 1'b1;    sclk <= 1'b0;
    end else begin
      done <= 1'b0;
      if (active) begin
        if (tick) begin
          div_cnt <= '0;
          sclk    <= ~sclk;
          if (!sclk)                rx_sr <= {rx_sr[6:0], miso};
          else if (bit_cnt == 3'd7) active <= 1'b0;
          else begin
            tx_sr   <= {tx_sr[6:0], 1'b1};
            bit_cnt <= bit_cnt + 3'd1;
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end else if (state != S_IDLE) begin
        active  <= 1'b1;
        bit_cnt <= '0;
        div_cnt <= '0;
        tx_sr   <= (state == S_FRAME) ? frame_byte : 8'hFF;
        cs_n    <= (state == S_WAKE) || (state == S_TAIL);
      end

      case (state)
        S_IDLE: if (start) begin
          op_q     <= opcode;
          arg_q    <= arg;
          typ_q    <= rsp_type;
          slow_q   <= wake || (opcode == 6'd0);
          idx      <= '0;
          poll_cnt <= '0;
          timeout  <= 1'b0;
          error    <= 1'b0;
          r1       <= 8'hFF;
          r2_hi    <= '0;
          r_word   <= '0;
          state    <= wake ? S_WAKE : S_FRAME;
        end
        S_WAKE: if (byte_end) begin
          idx <= idx + 1'b1;
          if (idx == IW'(WAKE_BYTES - 1)) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        S_FRAME: if (byte_end) begin
          idx <= idx + 1'b1;
          if (idx == IW'(7)) state <= S_POLL;
        end
        S_POLL: if (byte_end) begin
          if (!rx_sr[7]) begin
            r1    <= rx_sr;
            error <= (rx_sr > 8'h01);
            idx   <= '0;
            state <= (typ_q == 2'd1 || typ_q == 2'd2) ? S_EXTRA : S_TAIL;
          end else if (poll_cnt == PW'(POLL_LIMIT - 1)) begin
            timeout <= 1'b1;
            state   <= S_TAIL;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
          end
        end
        S_EXTRA: if (byte_end) begin
          if (typ_q == 2'd1) begin
            r2_hi <= rx_sr;
            state <= S_TAIL;
          end else begin
            r_word <= {r_word[23:0], rx_sr};
            idx    <= idx + 1'b1;
            if (idx == IW'(3)) state <= S_TAIL;
          end
        end
        S_TAIL: if (byte_end) begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_WAKE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (state == S_WAKE) |-> cs_n); // R1
  AST_FRAME_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n) (state == S_FRAME && active) |-> !cs_n); // R9
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) poll_cnt < PW'(POLL_LIMIT)); // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) done |-> !(timeout && error)); // R8
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!sclk && cs_n)); // R10
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (sclk && $past(sclk)) |-> $stable(mosi)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> $stable(arg_q)); // R11
endmodule

// File: tb/sim_spi_card_cmd_seq.sv
module sim_spi_card_cmd_seq;
  localparam int SLOW = 3, FAST = 1, WAKEN = 20, POLLN = 16;

  logic clk = 0, rst_n = 0, start = 0, wake = 0, miso = 1;
  logic [5:0] opcode = 0;
  logic [31:0] arg = 0;
  logic [1:0] rsp_type = 0;
  logic busy, done, timeout, error, cs_n, sclk, mosi;
  logic [7:0] r1, r2_hi;
  logic [31:0] r_word;

  spi_card_cmd_seq #(.SLOW_DIV(SLOW), .FAST_DIV(FAST), .WAKE_BYTES(WAKEN), .POLL_LIMIT(POLLN)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .wake(wake), .opcode(opcode), .arg(arg),
    .rsp_type(rsp_type), .busy(busy), .done(done), .timeout(timeout), .error(error),
    .r1(r1), .r2_hi(r2_hi), .r_word(r_word), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso));

  always #4 clk = ~clk;

  int vec = 0, bad = 0, hi_bytes = 0, hi_width = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  logic [7:0] card_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: capture MOSI on rising edge and pop the scoreboard
  logic [7:0] mon_sr = 0;
  int mon_bits = 0;
  longint t_rise = 0;
  always @(posedge sclk) begin
    t_rise = $time;
    mon_sr = {mon_sr[6:0], mosi};
    mon_bits++;
    if (mon_bits == 8) begin
      mon_bits = 0;
      if (!cs_n) begin
        if (exp_q.size() > 0) chk("R2 frame byte", {24'd0, mon_sr}, {24'd0, exp_q.pop_front()});
        else chk("R9 unexpected cs-low byte", 32'd1, 32'd0);
      end else begin
        hi_bytes++;
        chk("R1 cs-high byte value", {24'd0, mon_sr}, 32'hFF);
      end
    end
  end

  // card model: mode 0, silent for the eight frame bytes, then plays its queue
  logic [7:0] cur = 8'hFF;
  int cbit = 0, lowcnt = 0;
  always @(posedge cs_n) lowcnt = 0;
  always @(negedge sclk) begin
    hi_width = int'(($time - t_rise) / 8);
    cbit++;
    if (cbit == 8) begin
      cbit = 0;
      if (!cs_n) lowcnt++;
      cur = (!cs_n && lowcnt >= 8 && card_q.size() > 0) ? card_q.pop_front() : 8'hFF;
    end
    miso = cur[7 - cbit];
  end

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic run_cmd(input logic [5:0] op, input logic [31:0] a, input logic [1:0] t,
                         input logic [7:0] crc, input int reply_bytes);
    exp_q.push_back(8'hFF); exp_q.push_back({2'b01, op});
    exp_q.push_back(a[31:24]); exp_q.push_back(a[23:16]);
    exp_q.push_back(a[15:8]);  exp_q.push_back(a[7:0]);
    exp_q.push_back(crc);      exp_q.push_back(8'hFF);
    for (int i = 0; i < reply_bytes; i++) exp_q.push_back(8'hFF);
    hi_bytes = 0;
    @(negedge clk);
    opcode = op; arg = a; rsp_type = t; wake = 0; start = 1;
    @(negedge clk);
    start = 0;
    chk("R11 busy after start", {31'd0, busy}, 32'd1);
  endtask

  task automatic post_checks(input int half);
    chk("R2 scoreboard drained", exp_q.size(), 32'd0);
    chk("R9 one trailing cs-high byte", hi_bytes, 32'd1);
    chk("R4 sclk half period", hi_width, half);
    @(negedge clk);
    chk("R11 done is one cycle", {31'd0, done}, 32'd0);
    chk("R10 idle pins", {30'd0, sclk, cs_n}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; vec++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset sclk", {31'd0, sclk}, 32'd0);
    chk("R9 reset cs_n", {31'd0, cs_n}, 32'd1);
    chk("R11 reset busy/done", {30'd0, busy, done}, 32'd0);
    rst_n = 1;
    @(negedge clk);

    // R1 wake run
    hi_bytes = 0;
    wake = 1; start = 1; @(negedge clk); start = 0; wake = 0;
    wait_done();
    chk("R1 wake byte count", hi_bytes, WAKEN);
    chk("R4 wake uses slow clock", hi_width, SLOW + 1);
    chk("R1 no cs-low byte", exp_q.size(), 32'd0);

    // R3 R5 go-idle, status after two busy bytes
    card_q = '{8'hFF, 8'hFF, 8'h01};
    run_cmd(6'd0, 32'h0, 2'd0, 8'h95, 3);
    wait_done();
    chk("R5 status byte", {24'd0, r1}, 32'h01);
    chk("R8 idle status is no error", {31'd0, error}, 32'd0);
    chk("R6 no timeout", {31'd0, timeout}, 32'd0);
    post_checks(SLOW + 1);

    // R3 R7 interface condition, four-byte reply
    card_q = '{8'h01, 8'h00, 8'h00, 8'h01, 8'hAA};
    run_cmd(6'd8, 32'h0000_01AA, 2'd2, 8'h87, 5);
    wait_done();
    chk("R7 word reply", r_word, 32'h0000_01AA);
    chk("R5 status byte", {24'd0, r1}, 32'h01);
    post_checks(FAST + 1);

    // R7 two-byte reply, plus R11 start while busy
    card_q = '{8'hFF, 8'h00, 8'h5A};
    run_cmd(6'd13, 32'h1234_5678, 2'd1, 8'h00, 3);
    repeat (10) @(negedge clk);
    opcode = 6'd0; arg = 32'hDEAD_BEEF; wake = 1; start = 1;
    @(negedge clk);
    start = 0; wake = 0;
    wait_done();
    chk("R7 upper status byte", {24'd0, r2_hi}, 32'h5A);
    chk("R11 ignored start left status", {24'd0, r1}, 32'h00);
    post_checks(FAST + 1);
    repeat (40) @(negedge clk);
    chk("R11 no second run", {30'd0, busy, cs_n}, 32'd1);

    // R8 error status
    card_q = '{8'h04};
    run_cmd(6'd17, 32'h0000_0200, 2'd0, 8'h00, 1);
    wait_done();
    chk("R8 error flag", {31'd0, error}, 32'd1);
    chk("R8 status value", {24'd0, r1}, 32'h04);
    post_checks(FAST + 1);

    // R6 timeout
    card_q.delete();
    run_cmd(6'd55, 32'h0, 2'd2, 8'h00, POLLN);
    wait_done();
    chk("R6 timeout flag", {31'd0, timeout}, 32'd1);
    chk("R6 no error with timeout", {31'd0, error}, 32'd0);
    post_checks(FAST + 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule